// File: doc/BRIEF.md
# Board Control Register File

This block is the control-logic register bank of a development board. A host reaches it over a simple 32-bit read/write strobe bus. Only the low 20 address bits select a register, so the bank repeats through any larger window. It holds an 8-bit LED bar, an eight-character ASCII display buffer and a handful of scratch and configuration bytes. It also has a soft-reset register that reacts to one key value, and a bit-banged two-wire port that drives a serial EEPROM outside the block.

The display buffer can be loaded in two ways. A single character can be placed at any of eight slots. A whole 32-bit word can also be written; the block turns it into eight uppercase hexadecimal ASCII digits, with the most significant nibble in slot 0. The block presents the eight characters, the LED bits, the two-wire clock and data lines and a one-cycle reset-request pulse as outputs. A read returns its data on the cycle after the read strobe, and the read data holds until the next read.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset:
  - LED bar is 0x00, break register 0x0A, general output 0x00.
  - Two-wire output enable is 0x0, two-wire output register 0x3, select 0x1.
  - All eight display characters are 0x20 (space), and the reset request is low.
- R2: Only address bits [19:0] select a register, so higher address bits are ignored. An offset that names no register reads as 0 and a write to it changes nothing.
- R3: Offsets 0x200 and 0x210 read 0. Offset 0x208 reads 0x12 when the BIG_ENDIAN parameter is 1 and 0x10 when it is 0. Writes to these three offsets have no effect.
- R4: A write to offset 0x408 stores bits [7:0] as the LED bar, shown on `led_bar` and returned by a read.
- R5: A write to offset 0x410 fills all eight display slots. Slot k receives the uppercase ASCII hex digit of data nibble [31-4k:28-4k]. Slot k sits at bits [8k+7:8k] of `disp_chars`.
- R6: A write to offset 0x418 + 8k (k = 0..7) stores data bits [7:0] in slot k only. Display offsets read as 0.
- R7: A write of exactly 0x00000042 to offset 0x500 drives `soft_reset_req` high for the one cycle after the write edge. Any other value leaves it low.
- R8: Offsets 0x508 (break) and 0xA00 (general output) store and return data bits [7:0].
- R9: Offset 0xB08 stores and returns bits [1:0]. Offset 0xB18 stores and returns bit [0].
- R10: Offset 0xB10 stores and returns the full 32-bit word. Its bit 1 drives `eeprom_scl` and its bit 0 drives `eeprom_sda_out`.
- R11: Offset 0xB00 reads 0x2 with bit 0 replaced by `eeprom_sda_in` as sampled at the read edge.
- R12: Offset 0xA08 reads the 0xB10 word while the select bit is 1, and 0 while it is 0.
- R13: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A read and a write in the same cycle to the same register return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; low 20 bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| led_bar | output | 8 | LED bar bits |
| disp_chars | output | 8*DATA_W/4 | Display characters, slot k at bits [8k+7:8k] |
| soft_reset_req | output | 1 | One-cycle reset request |
| eeprom_scl | output | 1 | Two-wire clock to the EEPROM |
| eeprom_sda_out | output | 1 | Two-wire data to the EEPROM |
| eeprom_sda_in | input | 1 | Data line driven back by the EEPROM |

## Verification
A read strobe and a write strobe can be active in the same cycle on the same register. In that case the returned value and the stored value come from different sides of the clock edge. The bench first loads the LED bar with a known value, then raises both strobes together on offset 0x408 with a new value. It expects `bus_rdata` to show the old value and `led_bar` to show the new one after that edge. A second read then must return the new value.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int BCR_OFS_W = 20;

    // register offsets inside the 20-bit window
    localparam logic [BCR_OFS_W-1:0] OFS_SWITCH  = 20'h00200;
    localparam logic [BCR_OFS_W-1:0] OFS_STATUS  = 20'h00208;
    localparam logic [BCR_OFS_W-1:0] OFS_JUMPER  = 20'h00210;
    localparam logic [BCR_OFS_W-1:0] OFS_LED     = 20'h00408;
    localparam logic [BCR_OFS_W-1:0] OFS_HEXWORD = 20'h00410;
    localparam logic [BCR_OFS_W-1:0] OFS_CHAR0   = 20'h00418;
    localparam logic [BCR_OFS_W-1:0] OFS_SOFTRST = 20'h00500;
    localparam logic [BCR_OFS_W-1:0] OFS_BREAK   = 20'h00508;
    localparam logic [BCR_OFS_W-1:0] OFS_GPOUT   = 20'h00A00;
    localparam logic [BCR_OFS_W-1:0] OFS_GPIN    = 20'h00A08;
    localparam logic [BCR_OFS_W-1:0] OFS_TWI_IN  = 20'h00B00;
    localparam logic [BCR_OFS_W-1:0] OFS_TWI_OE  = 20'h00B08;
    localparam logic [BCR_OFS_W-1:0] OFS_TWI_OUT = 20'h00B10;
    localparam logic [BCR_OFS_W-1:0] OFS_TWI_SEL = 20'h00B18;

    localparam int CHAR_STRIDE_LOG2 = 3;

    localparam logic [7:0] SOFT_RESET_KEY = 8'h42;
    localparam logic [7:0] ASCII_SPACE    = 8'h20;
    localparam logic [7:0] BREAK_RST      = 8'h0A;
    localparam logic [1:0] TWI_IN_RST     = 2'b11;
    localparam logic [1:0] TWI_OUT_RST    = 2'b11;
    localparam logic [7:0] STATUS_BE      = 8'h12;
    localparam logic [7:0] STATUS_LE      = 8'h10;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_HEXWORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_BREAK,
        SEL_GPOUT,
        SEL_GPIN,
        SEL_TWI_IN,
        SEL_TWI_OE,
        SEL_TWI_OUT,
        SEL_TWI_SEL
    } bcr_sel_e;

    function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
        if (nib < 4'd10) begin
            return 8'h30 + {4'h0, nib};
        end
        return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import board_ctrl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [BCR_OFS_W-1:0] ofs,
    output bcr_sel_e             sel,
    output logic [IDX_W-1:0]     char_idx
);

    logic [BCR_OFS_W-1:0] rel;
    logic                 in_char_range;

    always_comb begin
        rel           = ofs - OFS_CHAR0;
        in_char_range = (ofs >= OFS_CHAR0)
                     && (rel[CHAR_STRIDE_LOG2-1:0] == '0)
                     && (32'(rel >> CHAR_STRIDE_LOG2) < 32'(NUM_CHARS));
        char_idx      = rel[CHAR_STRIDE_LOG2 +: IDX_W];
        sel           = SEL_NONE;
        case (ofs)
            OFS_SWITCH:  sel = SEL_SWITCH;
            OFS_STATUS:  sel = SEL_STATUS;
            OFS_JUMPER:  sel = SEL_JUMPER;
            OFS_LED:     sel = SEL_LED;
            OFS_HEXWORD: sel = SEL_HEXWORD;
            OFS_SOFTRST: sel = SEL_SOFTRST;
            OFS_BREAK:   sel = SEL_BREAK;
            OFS_GPOUT:   sel = SEL_GPOUT;
            OFS_GPIN:    sel = SEL_GPIN;
            OFS_TWI_IN:  sel = SEL_TWI_IN;
            OFS_TWI_OE:  sel = SEL_TWI_OE;
            OFS_TWI_OUT: sel = SEL_TWI_OUT;
            OFS_TWI_SEL: sel = SEL_TWI_SEL;
            default: begin
                if (in_char_range) begin
                    sel = SEL_CHAR;
                end
            end
        endcase
    end

endmodule

// File: rtl/bcr_hexfmt.sv
module bcr_hexfmt
    import board_ctrl_pkg::*;
#(
    parameter int NUM_CHARS = 8
) (
    input  logic [4*NUM_CHARS-1:0] word,
    output logic [8*NUM_CHARS-1:0] chars
);

    // slot 0 carries the most significant nibble
    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_digit
        assign chars[8*g +: 8] = hex_ascii(word[4*(NUM_CHARS-1-g) +: 4]);
    end

endmodule

// File: rtl/bcr_charbuf.sv
module bcr_charbuf
    import board_ctrl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_we,
    input  logic [8*NUM_CHARS-1:0] word_chars,
    input  logic                   char_we,
    input  logic [IDX_W-1:0]       char_idx,
    input  logic [7:0]             char_val,
    output logic [8*NUM_CHARS-1:0] chars
);

    logic [NUM_CHARS-1:0][7:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (word_we) begin
            buf_d = word_chars;
        end else if (char_we) begin
            for (int i = 0; i < NUM_CHARS; i++) begin
                if (char_idx == IDX_W'(i)) begin
                    buf_d[i] = char_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= {NUM_CHARS{ASCII_SPACE}};
        end else begin
            buf_q <= buf_d;
        end
    end

    assign chars = buf_q;

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [7:0]                led_bar,
    output logic [8*(DATA_W/4)-1:0]   disp_chars,
    output logic                      soft_reset_req,
    output logic                      eeprom_scl,
    output logic                      eeprom_sda_out,
    input  logic                      eeprom_sda_in
);

    localparam int NUM_CHARS = DATA_W / 4;
    localparam int IDX_W     = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
    localparam logic [DATA_W-1:0] STATUS_VAL =
        BIG_ENDIAN ? DATA_W'(STATUS_BE) : DATA_W'(STATUS_LE);

    typedef struct packed {
        logic [7:0]        led;
        logic [7:0]        brk;
        logic [7:0]        gpout;
        logic [1:0]        twi_oe;
        logic [DATA_W-1:0] twi_out;
        logic              twi_sel;
        logic [DATA_W-1:0] rdata;
        logic              rst_req;
    } regs_t;

    regs_t                r_d, r_q;
    bcr_sel_e             sel;
    logic [IDX_W-1:0]     char_idx;
    logic [8*NUM_CHARS-1:0] hex_chars;
    logic [DATA_W-1:0]    rd_mux;
    logic                 addr_unused_hi;

    assign addr_unused_hi = ^bus_addr[ADDR_W-1:BCR_OFS_W];

    bcr_decode #(
        .NUM_CHARS (NUM_CHARS),
        .IDX_W     (IDX_W)
    ) decode_i (
        .ofs      (bus_addr[BCR_OFS_W-1:0]),
        .sel      (sel),
        .char_idx (char_idx)
    );

    bcr_hexfmt #(
        .NUM_CHARS (NUM_CHARS)
    ) hexfmt_i (
        .word  (bus_wdata[4*NUM_CHARS-1:0]),
        .chars (hex_chars)
    );

    bcr_charbuf #(
        .NUM_CHARS (NUM_CHARS),
        .IDX_W     (IDX_W)
    ) charbuf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (bus_wr && (sel == SEL_HEXWORD)),
        .word_chars (hex_chars),
        .char_we    (bus_wr && (sel == SEL_CHAR)),
        .char_idx   (char_idx),
        .char_val   (bus_wdata[7:0]),
        .chars      (disp_chars)
    );

    // read multiplexer, built from the registered state (pre-write values)
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_STATUS:  rd_mux = STATUS_VAL;
            SEL_LED:     rd_mux = DATA_W'(r_q.led);
            SEL_BREAK:   rd_mux = DATA_W'(r_q.brk);
            SEL_GPOUT:   rd_mux = DATA_W'(r_q.gpout);
            SEL_GPIN:    rd_mux = r_q.twi_sel ? r_q.twi_out : '0;
            SEL_TWI_IN:  rd_mux = (DATA_W'(TWI_IN_RST) & ~DATA_W'(1))
                                | DATA_W'(eeprom_sda_in);
            SEL_TWI_OE:  rd_mux = DATA_W'(r_q.twi_oe);
            SEL_TWI_OUT: rd_mux = r_q.twi_out;
            SEL_TWI_SEL: rd_mux = DATA_W'(r_q.twi_sel);
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d         = r_q;
        r_d.rst_req = 1'b0;
        if (bus_wr) begin
            case (sel)
                SEL_LED:     r_d.led     = bus_wdata[7:0];
                SEL_BREAK:   r_d.brk     = bus_wdata[7:0];
                SEL_GPOUT:   r_d.gpout   = bus_wdata[7:0];
                SEL_TWI_OE:  r_d.twi_oe  = bus_wdata[1:0];
                SEL_TWI_OUT: r_d.twi_out = bus_wdata;
                SEL_TWI_SEL: r_d.twi_sel = bus_wdata[0];
                SEL_SOFTRST: r_d.rst_req = (bus_wdata == DATA_W'(SOFT_RESET_KEY));
                default: ;
            endcase
        end
        if (bus_rd) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.led     <= '0;
            r_q.brk     <= BREAK_RST;
            r_q.gpout   <= '0;
            r_q.twi_oe  <= '0;
            r_q.twi_out <= DATA_W'(TWI_OUT_RST);
            r_q.twi_sel <= 1'b1;
            r_q.rdata   <= '0;
            r_q.rst_req <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata      = r_q.rdata;
    assign led_bar        = r_q.led;
    assign soft_reset_req = r_q.rst_req;
    assign eeprom_scl     = r_q.twi_out[1];
    assign eeprom_sda_out = r_q.twi_out[0];

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic [7:0]              led_bar,
    input logic [8*(DATA_W/4)-1:0] disp_chars,
    input logic                    soft_reset_req,
    input logic                    eeprom_scl,
    input logic                    eeprom_sda_out
);

    // R7
    soft_reset_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_req |-> ($past(bus_wr)
                            && ($past(bus_addr[BCR_OFS_W-1:0]) == OFS_SOFTRST)
                            && ($past(bus_wdata) == DATA_W'(SOFT_RESET_KEY))));

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(led_bar));

    // R6
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(disp_chars));

    // R10
    twi_lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ($stable(eeprom_scl) && $stable(eeprom_sda_out)));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind board_ctrl_regs bcr_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .led_bar        (led_bar),
    .disp_chars     (disp_chars),
    .soft_reset_req (soft_reset_req),
    .eeprom_scl     (eeprom_scl),
    .eeprom_sda_out (eeprom_sda_out)
);

// File: tb/board_ctrl_regs_tb_top.sv
module board_ctrl_regs_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  leds;
    logic [63:0] disp;
    logic        rreq;
    logic        scl;
    logic        sda_o;
    logic        sda_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_ctrl_regs dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (addr),
        .bus_wr         (wr),
        .bus_rd         (rd),
        .bus_wdata      (wdata),
        .bus_rdata      (rdata),
        .led_bar        (leds),
        .disp_chars     (disp),
        .soft_reset_req (rreq),
        .eeprom_scl     (scl),
        .eeprom_sda_out (sda_o),
        .eeprom_sda_in  (sda_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic logic [63:0] hex_expect(input logic [31:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) begin
            logic [3:0] n;
            n = v[4*(7-k) +: 4];
            r[8*k +: 8] = (n < 10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
        end
        return r;
    endfunction

    task automatic t_reset_state();
        logic [31:0] d;
        chk("R1 led", leds, 0);
        chk("R1 disp", disp, 64'h2020202020202020);
        chk("R1 rreq", rreq, 0);
        chk("R1 scl/sda", {scl, sda_o}, 2'b11);
        bus_read(32'h508, d); chk("R1 break", d, 32'h0A);
        bus_read(32'hA00, d); chk("R1 gpout", d, 0);
        bus_read(32'hB08, d); chk("R1 oe", d, 0);
        bus_read(32'hB10, d); chk("R1 twi out", d, 3);
        bus_read(32'hB18, d); chk("R1 sel", d, 1);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        bus_write(32'h200, 32'hFFFF_FFFF);
        bus_write(32'h208, 32'hFFFF_FFFF);
        bus_write(32'h210, 32'hFFFF_FFFF);
        bus_read(32'h200, d); chk("R3 switch", d, 0);
        bus_read(32'h208, d); chk("R3 status", d, 32'h10);
        bus_read(32'h210, d); chk("R3 jumper", d, 0);
    endtask

    task automatic t_led_alias();
        logic [31:0] d;
        bus_write(32'hFFF0_0408, 32'h1234_56A5);
        chk("R4 led port", leds, 8'hA5);
        bus_read(32'h0000_0408, d); chk("R4 led read", d, 32'hA5);
        bus_read(32'h7A50_0408, d); chk("R2 alias read", d, 32'hA5);
        bus_write(32'h40C, 32'h0000_0011);
        chk("R2 unknown write ignored", leds, 8'hA5);
        bus_read(32'h40C, d); chk("R2 unknown read", d, 0);
        bus_read(32'h458, d); chk("R2 past last slot", d, 0);
    endtask

    task automatic t_hexword();
        bus_write(32'h410, 32'h0123_ABCD);
        chk("R5 hex literal", disp, 64'h4443424133323130);
        bus_write(32'h410, 32'hDEAD_BEEF);
        chk("R5 hex deadbeef", disp, hex_expect(32'hDEAD_BEEF));
        bus_write(32'h410, 32'hF0F0_9A5C);
        chk("R5 hex mixed", disp, hex_expect(32'hF0F0_9A5C));
    endtask

    task automatic t_chars();
        logic [63:0] exp;
        logic [31:0] d;
        exp = disp;
        bus_write(32'h418, 32'hFFFF_FF61);
        exp[7:0] = 8'h61;
        chk("R6 slot0", disp, exp);
        bus_write(32'h450, 32'h7A);
        exp[63:56] = 8'h7A;
        chk("R6 slot7", disp, exp);
        bus_write(32'h430, 32'h2A);
        exp[31:24] = 8'h2A;
        chk("R6 slot3", disp, exp);
        bus_write(32'h41C, 32'h55);
        chk("R6 misaligned ignored", disp, exp);
        bus_read(32'h430, d); chk("R6 slot read zero", d, 0);
    endtask

    task automatic t_softreset();
        bus_write(32'h500, 32'h42);
        chk("R7 pulse high", rreq, 1);
        @(negedge clk);
        chk("R7 pulse one cycle", rreq, 0);
        bus_write(32'h500, 32'h142);
        chk("R7 wrong value", rreq, 0);
        bus_write(32'h500, 32'h43);
        chk("R7 wrong value 2", rreq, 0);
    endtask

    task automatic t_byte_regs();
        logic [31:0] d;
        bus_write(32'h508, 32'hABCD_EF3C);
        bus_write(32'hA00, 32'h0000_01C3);
        bus_read(32'h508, d); chk("R8 break", d, 32'h3C);
        bus_read(32'hA00, d); chk("R8 gpout", d, 32'hC3);
        bus_write(32'hB08, 32'hFFFF_FFFF);
        bus_write(32'hB18, 32'hFFFF_FFFE);
        bus_read(32'hB08, d); chk("R9 oe mask", d, 32'h3);
        bus_read(32'hB18, d); chk("R9 sel mask", d, 0);
    endtask

    task automatic t_twi();
        logic [31:0] d;
        bus_write(32'hB10, 32'hCAFE_0002);
        chk("R10 lines", {scl, sda_o}, 2'b10);
        bus_read(32'hB10, d); chk("R10 full word", d, 32'hCAFE_0002);
        bus_write(32'hB10, 32'h0000_0001);
        chk("R10 lines 2", {scl, sda_o}, 2'b01);
        sda_i = 1'b1;
        bus_read(32'hB00, d); chk("R11 sda high", d, 32'h3);
        sda_i = 1'b0;
        bus_read(32'hB00, d); chk("R11 sda low", d, 32'h2);
        bus_write(32'hB10, 32'h1357_9BDF);
        bus_write(32'hB18, 0);
        bus_read(32'hA08, d); chk("R12 sel 0", d, 0);
        bus_write(32'hB18, 1);
        bus_read(32'hA08, d); chk("R12 sel 1", d, 32'h1357_9BDF);
    endtask

    task automatic t_read_write_same_cycle();
        logic [31:0] d;
        bus_write(32'h408, 32'h33);
        @(negedge clk);
        addr = 32'h408; wdata = 32'h5A; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R13 old value returned", rdata, 32'h33);
        chk("R13 new value stored", leds, 8'h5A);
        @(negedge clk);
        chk("R13 rdata held", rdata, 32'h33);
        bus_read(32'h408, d); chk("R13 reread", d, 32'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_readonly();
        t_led_alias();
        t_hexword();
        t_chars();
        t_softreset();
        t_byte_regs();
        t_twi();
        t_read_write_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule